// File: doc/BRIEF.md
# I2C command queue executor

This block runs the two command queues that belong to one I2C master. Software fills a queue one 32-bit command word at a time and reads back how many words the queue holds. The large queue holds 64 words and the small one holds 16. To run a queue, software writes an execute count for it and then sets that queue's start bit. The executor pops exactly that many words. It decodes the opcode in the low nibble of each command and turns write and read commands into byte operations for a bit-level engine, one request/acknowledge handshake per byte.

The opcodes are: 1 sets the target address, 8 is a report, 9 is a write and 10 is a read. A write carries its payload inline, starting in the byte after the command byte. Read bytes are packed into a small read FIFO of 32-bit words, least significant byte first. The first byte of each read is a marker, not data. Report commands with their interrupt bit set, read completion, NACKs and malformed commands each raise a one-cycle event. A NACK freezes the executor until a halt. A halt empties both queues and clears the overflow flags.

Top module: `i2cq_exec`

## Requirements
- R1: After reset the block is idle. Both queue word counts and the read FIFO level are 0, and no byte request is raised.
- R2: A load adds its word to the queue chosen by the queue-select bit and raises that queue's word count by one. Queue 0 is full at 64 words and queue 1 at 16. A load into a full queue is dropped and sets that queue's sticky overflow flag.
- R3: Start vector bit MASTER*2+q starts queue q when the executor is idle and the queue's execute count is nonzero. Queue 0 wins if both start. Start bits that belong to other masters, and starts while the executor is busy, do nothing.
- R4: A run pops exactly the execute count of words, or fewer if the queue empties first. At the end of the run the queue's word count returns to 0 and busy falls.
- R5: A set-address command (opcode 1 in bits [3:0]) loads bits [10:4] as the 7-bit target address used by every later byte request.
- R6: A write command (opcode 9) takes its byte count from bits [7:4]. Its payload is sent one byte per handshake, least significant byte first: bytes 1 to 3 of the command word first, then the following words from byte 0.
- R7: A report command (opcode 8) with bit 8 set pulses the report event of the running queue for one cycle. With bit 8 clear it raises no event.
- R8: A read command (opcode 10) takes its byte count N from bits [7:4]. It stores the marker byte {address, 1'b1} followed by the N received bytes into the read FIFO, packed least significant byte first. The result is N/4+1 words. The read-done event pulses when the read finishes.
- R9: A NACK on a byte pulses the running queue's NACK event. The executor then stays busy and ignores starts until halt is asserted. A halt empties both queues, clears both overflow flags and returns to idle.
- R10: An unknown opcode, or write payload that runs past the execute count, pulses the generic error event, ends the run and empties the queue.
- R11: A byte request keeps its direction, address and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_wr_i | input | 1 | Load one command word |
| ld_q_i | input | 1 | Queue selected by the load |
| ld_data_i | input | 32 | Command word to load |
| q_cnt_o | output | 2x7 | Word count of each queue |
| q_ovf_o | output | 2 | Sticky overflow flag of each queue |
| exec_wr_i | input | 1 | Write an execute count |
| exec_q_i | input | 1 | Queue selected by the execute-count write |
| exec_cnt_i | input | 7 | Execute count value |
| start_i | input | 4 | Start vector shared by all masters |
| halt_i | input | 1 | Halt: empty queues, clear flags, go idle |
| busy_o | output | 1 | Executor not idle |
| op_req_o | output | 1 | Byte request to the bit engine |
| op_rd_o | output | 1 | Request is a read byte |
| op_addr_o | output | 7 | Target address of the request |
| op_wdata_o | output | 8 | Byte to write |
| op_ack_i | input | 1 | Bit engine finished the byte |
| op_nack_i | input | 1 | Byte was not acknowledged on the bus |
| op_rdata_i | input | 8 | Byte received |
| rd_pop_i | input | 1 | Pop the read FIFO |
| rd_data_o | output | 32 | Head of the read FIFO |
| rd_level_o | output | 3 | Words held in the read FIFO |
| rpt_evt_o | output | 2 | Report event of each queue |
| rd_done_o | output | 1 | Read finished |
| nack_err_o | output | 2 | NACK event of each queue |
| gen_err_o | output | 1 | Malformed command event |

## Verification
The handshake assertion assumes that the bit engine pulses acknowledge for a single cycle, only while a request is up, and that halt is the only other thing that can withdraw a request. The bench responder drops acknowledge on the cycle after it raises it and never acknowledges while idle. The assertions also assume that read runs never overfill the read FIFO. The bench therefore drains every read before the next read starts, and it keeps each read at 15 bytes or fewer.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  typedef enum logic [3:0] {
    OPC_SETA = 4'd1,
    OPC_RPT  = 4'd8,
    OPC_WR   = 4'd9,
    OPC_RD   = 4'd10
  } opc_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WR, S_LOAD, S_RD, S_STOP
  } st_e;
endpackage

// File: rtl/i2cq_fifo.sv
// Word FIFO; DEPTH must be a power of two.
module i2cq_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             clr_ovf_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp, wp_n, rp_n;
  logic [CW-1:0]    cnt, cnt_n;
  logic             ovf, ovf_n;
  logic             do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem[rp];
  assign count_o = cnt;
  assign ovf_o   = ovf;

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    cnt_n = cnt;
    ovf_n = clr_ovf_i ? 1'b0 : (ovf | (push_i & full_o));
    if (flush_i) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = wp + AW'(1);
      if (do_pop)  rp_n = rp + AW'(1);
      if (do_push && !do_pop)      cnt_n = cnt + CW'(1);
      else if (do_pop && !do_push) cnt_n = cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
      ovf <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= data_i;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R2
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && full_o && !clr_ovf_i |=> ovf_o);
  // R4
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> count_o == '0);
endmodule

// File: rtl/i2cq_rdpack.sv
// Packs bytes into 32-bit words, least significant byte first.
module i2cq_rdpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        flush_i,
  output logic        word_vld_o,
  output logic [31:0] word_o
);
  logic [23:0] acc, acc_n;
  logic [1:0]  idx, idx_n;

  assign word_vld_o = (byte_vld_i && idx == 2'd3) || (flush_i && idx != 2'd0);
  assign word_o     = byte_vld_i ? {byte_i, acc} : {8'h00, acc};

  always_comb begin
    acc_n = acc;
    idx_n = idx;
    if (byte_vld_i) begin
      idx_n = idx + 2'd1;
      case (idx)
        2'd0:    acc_n[7:0]   = byte_i;
        2'd1:    acc_n[15:8]  = byte_i;
        2'd2:    acc_n[23:16] = byte_i;
        default: acc_n        = '0;
      endcase
    end else if (flush_i) begin
      acc_n = '0;
      idx_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      idx <= '0;
    end else begin
      acc <= acc_n;
      idx <= idx_n;
    end
  end
endmodule

// File: rtl/i2cq_exec.sv
module i2cq_exec #(
  parameter int Q0_DEPTH    = 64,
  parameter int Q1_DEPTH    = 16,
  parameter int RD_DEPTH    = 4,
  parameter int NUM_MASTERS = 2,
  parameter int MASTER      = 0,
  localparam int CW  = $clog2(Q0_DEPTH + 1),
  localparam int RLW = $clog2(RD_DEPTH + 1),
  localparam int SW  = 2 * NUM_MASTERS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_wr_i,
  input  logic                ld_q_i,
  input  logic [31:0]         ld_data_i,
  output logic [1:0][CW-1:0]  q_cnt_o,
  output logic [1:0]          q_ovf_o,
  input  logic                exec_wr_i,
  input  logic                exec_q_i,
  input  logic [CW-1:0]       exec_cnt_i,
  input  logic [SW-1:0]       start_i,
  input  logic                halt_i,
  output logic                busy_o,
  output logic                op_req_o,
  output logic                op_rd_o,
  output logic [6:0]          op_addr_o,
  output logic [7:0]          op_wdata_o,
  input  logic                op_ack_i,
  input  logic                op_nack_i,
  input  logic [7:0]          op_rdata_i,
  input  logic                rd_pop_i,
  output logic [31:0]         rd_data_o,
  output logic [RLW-1:0]      rd_level_o,
  output logic [1:0]          rpt_evt_o,
  output logic                rd_done_o,
  output logic [1:0]          nack_err_o,
  output logic                gen_err_o
);
  import i2cq_pkg::*;
  localparam int SB = 2 * MASTER;

  logic [1:0]        q_push, q_pop, q_flush, q_full, q_empty;
  logic [1:0][31:0]  q_dout;
  logic [1:0]        go;

  st_e               st, st_n;
  logic              aq, aq_n;
  logic [CW-1:0]     remain, remain_n;
  logic [31:0]       cur, cur_n;
  logic [1:0]        bptr, bptr_n;
  logic [3:0]        left, left_n;
  logic [6:0]        addr, addr_n;
  logic [1:0][CW-1:0] xcnt;
  logic [1:0]        rpt_n, nack_n;
  logic              rdd_n, gen_n;
  logic              pad_vld, rd_flush, pk_vld, pk_wvld;
  logic [7:0]        pk_byte;
  logic [31:0]       pk_word, head;
  logic              rd_full, rd_empty, rd_ovf;

  assign go = start_i[SB +: 2];

  for (genvar g = 0; g < 2; g++) begin : g_q
    assign q_push[g] = ld_wr_i && (ld_q_i == 1'(g));
    i2cq_fifo #(.DEPTH((g == 0) ? Q0_DEPTH : Q1_DEPTH), .WIDTH(32), .CW(CW)) i_q (
      .clk(clk), .rst_n(rst_n), .flush_i(q_flush[g]), .clr_ovf_i(halt_i),
      .push_i(q_push[g]), .data_i(ld_data_i), .pop_i(q_pop[g]),
      .data_o(q_dout[g]), .count_o(q_cnt_o[g]), .full_o(q_full[g]),
      .empty_o(q_empty[g]), .ovf_o(q_ovf_o[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 xcnt[g] <= '0;
      else if (exec_wr_i && exec_q_i == 1'(g))    xcnt[g] <= exec_cnt_i;
    end
  end

  assign head = q_dout[aq];

  always_comb begin
    st_n = st; aq_n = aq; remain_n = remain; cur_n = cur;
    bptr_n = bptr; left_n = left; addr_n = addr;
    q_pop = '0; q_flush = '0; pad_vld = 1'b0; rd_flush = 1'b0;
    rpt_n = '0; nack_n = '0; rdd_n = 1'b0; gen_n = 1'b0;
    case (st)
      S_IDLE: begin
        if (go[0] && xcnt[0] != '0) begin
          aq_n = 1'b0; remain_n = xcnt[0]; st_n = S_FETCH;
        end else if (go[1] && xcnt[1] != '0) begin
          aq_n = 1'b1; remain_n = xcnt[1]; st_n = S_FETCH;
        end
      end
      S_FETCH: begin
        if (remain == '0 || q_empty[aq]) begin
          q_flush[aq] = 1'b1; st_n = S_IDLE;
        end else begin
          q_pop[aq] = 1'b1; remain_n = remain - CW'(1); cur_n = head;
          case (head[3:0])
            OPC_SETA: addr_n = head[10:4];
            OPC_RPT:  rpt_n[aq] = head[8];
            OPC_WR:   begin left_n = head[7:4]; bptr_n = 2'd1; st_n = S_WR; end
            OPC_RD:   begin left_n = head[7:4]; pad_vld = 1'b1; st_n = S_RD; end
            default:  begin gen_n = 1'b1; q_flush[aq] = 1'b1; st_n = S_IDLE; end
          endcase
        end
      end
      S_WR: begin
        if (left == '0) st_n = S_FETCH;
        else if (op_ack_i) begin
          if (op_nack_i) begin
            nack_n[aq] = 1'b1; st_n = S_STOP;
          end else begin
            left_n = left - 4'd1; bptr_n = bptr + 2'd1;
            if (left == 4'd1)       st_n = S_FETCH;
            else if (bptr == 2'd3)  st_n = S_LOAD;
          end
        end
      end
      S_LOAD: begin
        if (remain == '0 || q_empty[aq]) begin
          gen_n = 1'b1; q_flush[aq] = 1'b1; st_n = S_IDLE;
        end else begin
          q_pop[aq] = 1'b1; remain_n = remain - CW'(1);
          cur_n = head; bptr_n = 2'd0; st_n = S_WR;
        end
      end
      S_RD: begin
        if (left == '0) begin
          rd_flush = 1'b1; rdd_n = 1'b1; st_n = S_FETCH;
        end else if (op_ack_i) begin
          if (op_nack_i) begin
            nack_n[aq] = 1'b1; st_n = S_STOP;
          end else left_n = left - 4'd1;
        end
      end
      default: ;
    endcase
    if (halt_i) begin
      st_n = S_IDLE; q_flush = 2'b11;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; aq <= 1'b0; remain <= '0; cur <= '0; bptr <= '0;
      left <= '0; addr <= '0; rpt_evt_o <= '0; nack_err_o <= '0;
      rd_done_o <= 1'b0; gen_err_o <= 1'b0;
    end else begin
      st <= st_n; aq <= aq_n; remain <= remain_n; cur <= cur_n; bptr <= bptr_n;
      left <= left_n; addr <= addr_n; rpt_evt_o <= rpt_n; nack_err_o <= nack_n;
      rd_done_o <= rdd_n; gen_err_o <= gen_n;
    end
  end

  assign busy_o     = (st != S_IDLE);
  assign op_req_o   = (st == S_WR || st == S_RD) && left != '0;
  assign op_rd_o    = (st == S_RD);
  assign op_addr_o  = addr;
  assign op_wdata_o = cur[8*bptr +: 8];

  assign pk_vld  = pad_vld || (st == S_RD && left != '0 && op_ack_i && !op_nack_i);
  assign pk_byte = pad_vld ? {addr, 1'b1} : op_rdata_i;

  i2cq_rdpack i_pack (
    .clk(clk), .rst_n(rst_n), .byte_vld_i(pk_vld), .byte_i(pk_byte),
    .flush_i(rd_flush), .word_vld_o(pk_wvld), .word_o(pk_word));

  i2cq_fifo #(.DEPTH(RD_DEPTH), .WIDTH(32), .CW(RLW)) i_rdq (
    .clk(clk), .rst_n(rst_n), .flush_i(1'b0), .clr_ovf_i(1'b0),
    .push_i(pk_wvld), .data_i(pk_word), .pop_i(rd_pop_i),
    .data_o(rd_data_o), .count_o(rd_level_o), .full_o(rd_full),
    .empty_o(rd_empty), .ovf_o(rd_ovf));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_req_o && !op_ack_i && !halt_i |=> op_req_o && $stable(op_wdata_o)
      && $stable(op_rd_o) && $stable(op_addr_o));
  // R9
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|nack_err_o) && !halt_i |=> busy_o);
  // R10
  gen_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_err_o |-> !busy_o);
  // R7
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rpt_evt_o, rd_done_o, nack_err_o, gen_err_o}));
  // R3
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(|go));
endmodule

// File: tb/test_i2cq_exec.sv
`timescale 1ns/1ps
module test_i2cq_exec;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             ld_wr, ld_q, exec_wr, exec_q, halt, rd_pop;
  logic [31:0]      ld_data;
  logic [6:0]       exec_cnt;
  logic [3:0]       start;
  logic [1:0][6:0]  q_cnt;
  logic [1:0]       q_ovf, rpt_evt, nack_err;
  logic             busy, op_req, op_rd, rd_done, gen_err;
  logic [6:0]       op_addr;
  logic [7:0]       op_wdata, op_rdata;
  logic             op_ack, op_nack;
  logic [31:0]      rd_data;
  logic [2:0]       rd_level;

  int nchk = 0, nfail = 0;
  int rpt_c0 = 0, rpt_c1 = 0, rdd_c = 0, nack_c0 = 0, gen_c = 0;
  int opn = 0, nack_at = -1, wn = 0;
  logic [7:0] wlog [32];
  logic [6:0] last_addr;
  logic [7:0] rsrc = 8'h40;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2cq_exec i_i2cq_exec (
    .clk(clk), .rst_n(rst_n), .ld_wr_i(ld_wr), .ld_q_i(ld_q), .ld_data_i(ld_data),
    .q_cnt_o(q_cnt), .q_ovf_o(q_ovf), .exec_wr_i(exec_wr), .exec_q_i(exec_q),
    .exec_cnt_i(exec_cnt), .start_i(start), .halt_i(halt), .busy_o(busy),
    .op_req_o(op_req), .op_rd_o(op_rd), .op_addr_o(op_addr), .op_wdata_o(op_wdata),
    .op_ack_i(op_ack), .op_nack_i(op_nack), .op_rdata_i(op_rdata),
    .rd_pop_i(rd_pop), .rd_data_o(rd_data), .rd_level_o(rd_level),
    .rpt_evt_o(rpt_evt), .rd_done_o(rd_done), .nack_err_o(nack_err),
    .gen_err_o(gen_err));

  // Bit engine model and event counters, all at the falling edge
  always @(negedge clk) begin
    if (rpt_evt[0]) rpt_c0++;
    if (rpt_evt[1]) rpt_c1++;
    if (rd_done)    rdd_c++;
    if (nack_err[0]) nack_c0++;
    if (gen_err)    gen_c++;
    if (op_ack) begin
      op_ack  <= 1'b0;
      op_nack <= 1'b0;
    end else if (op_req) begin
      last_addr = op_addr;
      if (!op_rd) begin
        wlog[wn % 32] = op_wdata;
        wn++;
      end
      op_rdata <= rsrc;
      rsrc = rsrc + 8'd1;
      op_nack <= (opn == nack_at);
      op_ack  <= 1'b1;
      opn++;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic load(input logic q, input logic [31:0] w);
    @(negedge clk); ld_wr = 1'b1; ld_q = q; ld_data = w;
    @(negedge clk); ld_wr = 1'b0;
  endtask

  task automatic set_exec(input logic q, input int n);
    @(negedge clk); exec_wr = 1'b1; exec_q = q; exec_cnt = 7'(n);
    @(negedge clk); exec_wr = 1'b0;
  endtask

  task automatic kick(input int bitn);
    @(negedge clk); start = 4'(1 << bitn);
    @(negedge clk); start = '0;
  endtask

  task automatic run_wait(input string r);
    int t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    chk(r, busy, 1'b0);
    @(negedge clk);
  endtask

  task automatic do_halt;
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 q0 count", q_cnt[0], 0);
    chk("R1 q1 count", q_cnt[1], 0);
    chk("R1 rd level", rd_level, 0);
    chk("R1 req", op_req, 0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 17; i++) load(1'b1, 32'h108);
    chk("R2 q1 count at full", q_cnt[1], 16);
    chk("R2 ovf flags", q_ovf, 2'b10);
    kick(2);  // start bit of the other master
    repeat (3) @(negedge clk);
    chk("R3 foreign start ignored", busy, 0);
    chk("R3 q1 count kept", q_cnt[1], 16);
    for (int i = 0; i < 65; i++) load(1'b0, 32'h008);
    chk("R2 q0 count at full", q_cnt[0], 64);
    chk("R2 ovf both", q_ovf, 2'b11);
    do_halt();
    chk("R9 halt empties", {q_cnt[1], q_cnt[0]}, 0);
    chk("R9 halt clears ovf", q_ovf, 0);
  endtask

  task automatic t_write;
    int w0 = wn, r0 = rpt_c0;
    load(1'b0, 32'h0000_0521);   // address 0x52
    load(1'b0, 32'hC3B2_A159);   // write 5 bytes
    load(1'b0, 32'h0000_E5D4);
    load(1'b0, 32'h0000_0108);   // report, irq
    chk("R2 count", q_cnt[0], 4);
    set_exec(1'b0, 4);
    kick(0);
    run_wait("R4 write run ends");
    chk("R6 byte count", wn - w0, 5);
    chk("R6 b0", wlog[(w0) % 32], 8'hA1);
    chk("R6 b1", wlog[(w0+1) % 32], 8'hB2);
    chk("R6 b2", wlog[(w0+2) % 32], 8'hC3);
    chk("R6 b3", wlog[(w0+3) % 32], 8'hD4);
    chk("R6 b4", wlog[(w0+4) % 32], 8'hE5);
    chk("R5 address", last_addr, 7'h52);
    chk("R7 report", rpt_c0 - r0, 1);
    chk("R4 count cleared", q_cnt[0], 0);
  endtask

  task automatic t_exact;
    int r0 = rpt_c0;
    load(1'b0, 32'h108); load(1'b0, 32'h108); load(1'b0, 32'h108);
    set_exec(1'b0, 2);
    kick(0);
    run_wait("R4 exact run ends");
    chk("R4 only counted words run", rpt_c0 - r0, 2);
    chk("R4 leftover discarded", q_cnt[0], 0);
  endtask

  task automatic t_noirq;
    int r1 = rpt_c1;
    load(1'b1, 32'h008);
    set_exec(1'b1, 1);
    kick(1);
    run_wait("R7 run ends");
    chk("R7 no event without bit 8", rpt_c1 - r1, 0);
  endtask

  task automatic t_read;
    int d0 = rdd_c;
    rsrc = 8'h40;
    load(1'b1, 32'h1A1);     // address 0x1A
    load(1'b1, 32'h06A);     // read 6
    set_exec(1'b1, 2);
    kick(1);
    run_wait("R8 read run ends");
    chk("R8 done event", rdd_c - d0, 1);
    chk("R8 level 6/4+1", rd_level, 2);
    chk("R5 read address", last_addr, 7'h1A);
    chk("R8 word0", rd_data, 32'h4241_4035);
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
    chk("R8 word1", rd_data, 32'h0045_4443);
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
    chk("R8 drained", rd_level, 0);
    load(1'b1, 32'h00A);     // read 0 bytes
    set_exec(1'b1, 1);
    kick(1);
    run_wait("R8 empty read ends");
    chk("R8 zero-length level", rd_level, 1);
    chk("R8 marker only", rd_data, 32'h0000_0035);
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
  endtask

  task automatic t_nack;
    int n0 = nack_c0, w0 = wn;
    load(1'b0, 32'h211);
    load(1'b0, 32'h3322_1139);  // write 3 bytes
    set_exec(1'b0, 2);
    nack_at = opn + 1;
    kick(0);
    repeat (20) @(negedge clk);
    nack_at = -1;
    chk("R9 nack event", nack_c0 - n0, 1);
    chk("R9 stays busy", busy, 1);
    chk("R9 bytes before stop", wn - w0, 2);
    load(1'b0, 32'h108);
    kick(0);
    repeat (5) @(negedge clk);
    chk("R9 start ignored while stopped", q_cnt[0], 1);
    do_halt();
    chk("R9 halt to idle", busy, 0);
    chk("R9 halt empties", q_cnt[0], 0);
  endtask

  task automatic t_bad;
    int g0 = gen_c, r1 = rpt_c1, w0 = wn;
    load(1'b1, 32'h003);
    load(1'b1, 32'h108);
    set_exec(1'b1, 2);
    kick(1);
    run_wait("R10 bad opcode ends");
    chk("R10 error event", gen_c - g0, 1);
    chk("R10 later words skipped", rpt_c1 - r1, 0);
    chk("R10 queue emptied", q_cnt[1], 0);
    load(1'b0, 32'hC3B2_A159);
    load(1'b0, 32'h0000_E5D4);
    set_exec(1'b0, 1);
    kick(0);
    run_wait("R10 truncated write ends");
    chk("R10 truncated error", gen_c - g0, 2);
    chk("R10 truncated bytes", wn - w0, 3);
    chk("R10 truncated emptied", q_cnt[0], 0);
  endtask

  initial begin
    rst_n = 1'b0; ld_wr = 0; ld_q = 0; ld_data = 0; exec_wr = 0; exec_q = 0;
    exec_cnt = 0; start = 0; halt = 0; rd_pop = 0;
    op_ack = 0; op_nack = 0; op_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_write();
    t_exact();
    t_noirq();
    t_read();
    t_nack();
    t_bad();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL R4 watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule